// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It stores 32-bit trace words in an on-chip circular RAM and gives software a small register map to manage that RAM. While capture runs, every valid trace word goes to the write pointer, and the write pointer wraps at the RAM depth. A sticky status bit records that the RAM has wrapped, which means older words were overwritten. Software stops capture in one of three ways:
- directly, through the capture control register;
- after a trigger, once a programmed number of further words has been stored;
- at the end of a manual flush handshake with the upstream trace source.

When frame formatting is enabled, the block pads the last partial frame with zero words up to a 4-word boundary before it reports that it has stopped. A stopped buffer can then be drained through a read data window, where each read returns one word and advances the read pointer. Software can also clear or preload the RAM through a write data window, and it can set either pointer directly.

Register reads are pipelined. A one-cycle read strobe returns its data with a valid flag two clock cycles later. Register writes take effect at the clock edge where the write strobe is sampled.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset, the registers read as follows:
  - read pointer (0x014), write pointer (0x018), trigger count (0x01C), capture control (0x020), status (0x00C) and formatter control (0x304) all read 0;
  - formatter status (0x300) reads 2, meaning bit 1 "stopped" is set;
  - `flush_req` is low.
- R2: A one-cycle `bus_rd` strobe produces `bus_rvalid` and the register value on `bus_rdata` exactly two cycles later. The size register at 0x004 returns DEPTH, and its bit 31 is always 0.
- R3: When bit 0 = 1 is written to capture control (0x020) while stopped, capture starts and formatter status bit 1 clears. From then on, each cycle with `trc_valid` high stores `trc_data` at the write pointer, and the write pointer advances modulo DEPTH.
- R4: Status bit 0 (0x00C) sets when a captured or padding word is stored at address DEPTH-1. It stays set until software writes the write pointer register. Wraps caused by the write window do not set it.
- R5: Each read of the read window (0x010) returns the word at the read pointer and then advances the read pointer modulo DEPTH. The read pointer register (0x014) can be written at any time.
- R6: While stopped, a write to the write window (0x024) stores the word at the write pointer and advances that pointer. A write to 0x018 loads the write pointer. Both writes are ignored while capture is running or padding.
- R7: Writing 0 to capture control bit 0 stops capture:
  - with formatter control bit 0 = 1, zero words are stored until the write pointer is a multiple of 4, and only then is stopped reported;
  - with formatter control bit 0 = 0, capture stops at once without padding.
- R8: With formatter control bit 13 = 1, a `trc_trig` pulse during capture arms the trigger countdown. The word offered in the trigger cycle is stored but not counted. After arming:
  - exactly N more valid words are stored, where N is the trigger count register value (0x01C);
  - the trigger count register decrements once per stored word;
  - capture then stops, padding as in R7, and further words are dropped.

  Restarting capture disarms the countdown.
- R9: With formatter control bit 13 = 0, `trc_trig` has no effect. Capture continues and the trigger count register is unchanged.
- R10: Writing formatter control with bit 6 = 1 raises `flush_req`, and bit 6 reads back as 1. In the cycle after `flush_ack` is seen, both `flush_req` and bit 6 return to 0.
- R11: If formatter control bit 12 = 1 when a flush completes during capture, capture stops, padding as in R7. If bit 12 = 0, capture continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data |
| bus_rvalid | output | 1 | Read data valid, two cycles after bus_rd |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | DATA_W | Trace word |
| trc_trig | input | 1 | Trigger event |
| flush_req | output | 1 | Manual flush in progress |
| flush_ack | input | 1 | Upstream flush completed |

## Verification
The bench builds the block with DEPTH = 16 and CNT_W = 8. With these values, a trigger started a few words before the top of the RAM wraps the write pointer, raises the full bit and then pads at low addresses, all in a short run. Starting from different write pointer values brings every padding length (zero to three words) within reach. It also exercises wrap of the read window and of the write window, checks that window writes do not set the full bit, and covers flush completion both with and without the stop bit.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] A_SIZE   = 12'h004;
  localparam logic [REG_AW-1:0] A_STAT   = 12'h00C;
  localparam logic [REG_AW-1:0] A_RDWIN  = 12'h010;
  localparam logic [REG_AW-1:0] A_RDPTR  = 12'h014;
  localparam logic [REG_AW-1:0] A_WRPTR  = 12'h018;
  localparam logic [REG_AW-1:0] A_TRGCNT = 12'h01C;
  localparam logic [REG_AW-1:0] A_CTRL   = 12'h020;
  localparam logic [REG_AW-1:0] A_WRWIN  = 12'h024;
  localparam logic [REG_AW-1:0] A_FSTAT  = 12'h300;
  localparam logic [REG_AW-1:0] A_FCTRL  = 12'h304;

  localparam int B_FMT_EN   = 0;
  localparam int B_FLUSH    = 6;
  localparam int B_STOP_FL  = 12;
  localparam int B_STOP_TRG = 13;
  localparam int B_STOPPED  = 1;

  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_RUN  = 2'd1,
    ST_PAD  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/tcb_ram.sv
`timescale 1ns/1ps
// Simple dual-port RAM, registered read, no reset on the array.
module tcb_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcb_ptr.sv
`timescale 1ns/1ps
// Word pointer, wraps naturally at 2**AW; load wins over increment.
module tcb_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (ld)  ptr <= ld_val;
    else if (inc) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/tcb_ctrl.sv
`timescale 1ns/1ps
// Capture sequencer: run / pad / stopped, trigger countdown.
module tcb_ctrl import tcb_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_on,
  input  logic             cap_off,
  input  logic             fmt_en,
  input  logic             stop_trg,
  input  logic             stop_fl,
  input  logic             flush_done,
  input  logic             trc_valid,
  input  logic             trc_trig,
  input  logic [1:0]       wptr_lo,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_val,
  output cap_state_t       state_o,
  output logic             store_o,
  output logic             pad_o,
  output logic [CNT_W-1:0] trg_cnt_o
);
  cap_state_t state;
  logic       armed;
  logic       running;
  logic       cnt_done;
  logic       stop_now;

  assign running  = (state == ST_RUN);
  assign cnt_done = armed && (trg_cnt_o == '0);
  assign stop_now = running && (cap_off || cnt_done || (flush_done && stop_fl));
  assign store_o  = running && trc_valid && !cnt_done;
  assign pad_o    = (state == ST_PAD) && (wptr_lo != 2'b00);
  assign state_o  = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_STOP;
    end else begin
      unique case (state)
        ST_STOP: if (cap_on) state <= ST_RUN;
        ST_RUN:  if (stop_now) state <= fmt_en ? ST_PAD : ST_STOP;
        ST_PAD:  if (wptr_lo == 2'b00) state <= ST_STOP;
        default: state <= ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (state == ST_STOP && cap_on) begin
      armed <= 1'b0;
    end else if (running && trc_trig && stop_trg) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   trg_cnt_o <= '0;
    else if (cnt_ld)           trg_cnt_o <= cnt_val;
    else if (armed && store_o) trg_cnt_o <= trg_cnt_o - 1'b1;
  end

  AST_TRIG_HALT: assert property (@(posedge clk) disable iff (rst)
    (running && cnt_done) |=> (state != ST_RUN)); // R8
  AST_PAD_END: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAD && wptr_lo == 2'b00) |=> (state == ST_STOP)); // R7
  AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!armed && !cnt_ld) |=> $stable(trg_cnt_o)); // R9
endmodule

// File: rtl/trace_capture_buffer.sv
`timescale 1ns/1ps
module trace_capture_buffer import tcb_pkg::*; #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trc_trig,
  output logic              flush_req,
  input  logic              flush_ack
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [DATA_W-1:0] SIZE_WORD = DATA_W'(DEPTH);

  // Register decode
  logic wr_rdptr, wr_wrptr, wr_trg, wr_ctrl, wr_wrwin, wr_fctrl, rd_win;
  assign wr_rdptr = bus_wr && (bus_addr == A_RDPTR);
  assign wr_wrptr = bus_wr && (bus_addr == A_WRPTR);
  assign wr_trg   = bus_wr && (bus_addr == A_TRGCNT);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_wrwin = bus_wr && (bus_addr == A_WRWIN);
  assign wr_fctrl = bus_wr && (bus_addr == A_FCTRL);
  assign rd_win   = bus_rd && (bus_addr == A_RDWIN);

  // Control and formatter registers
  logic cap_en, fmt_en, stop_fl, stop_trg, flush_pend, full;
  logic flush_done;
  assign flush_done = flush_pend && flush_ack;
  assign flush_req  = flush_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en   <= 1'b0;
      fmt_en   <= 1'b0;
      stop_fl  <= 1'b0;
      stop_trg <= 1'b0;
    end else begin
      if (wr_ctrl) cap_en <= bus_wdata[0];
      if (wr_fctrl) begin
        fmt_en   <= bus_wdata[B_FMT_EN];
        stop_fl  <= bus_wdata[B_STOP_FL];
        stop_trg <= bus_wdata[B_STOP_TRG];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 flush_pend <= 1'b0;
    else if (wr_fctrl && bus_wdata[B_FLUSH]) flush_pend <= 1'b1;
    else if (flush_done)                     flush_pend <= 1'b0;
  end

  // Capture sequencer
  cap_state_t       st;
  logic             store, pad_we;
  logic [CNT_W-1:0] trg_cnt;
  logic [AW-1:0]    wptr, rptr;
  logic             stopped;
  assign stopped = (st == ST_STOP);

  tcb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cap_on     (wr_ctrl && bus_wdata[0]),
    .cap_off    (wr_ctrl && !bus_wdata[0]),
    .fmt_en     (fmt_en),
    .stop_trg   (stop_trg),
    .stop_fl    (stop_fl),
    .flush_done (flush_done),
    .trc_valid  (trc_valid),
    .trc_trig   (trc_trig),
    .wptr_lo    (wptr[1:0]),
    .cnt_ld     (wr_trg),
    .cnt_val    (bus_wdata[CNT_W-1:0]),
    .state_o    (st),
    .store_o    (store),
    .pad_o      (pad_we),
    .trg_cnt_o  (trg_cnt)
  );

  // Write side: capture, padding or software window
  logic              sw_win_we, sw_ptr_ld, ram_we, cap_we;
  logic [DATA_W-1:0] ram_wdata;
  assign sw_win_we = wr_wrwin && stopped;
  assign sw_ptr_ld = wr_wrptr && stopped;
  assign cap_we    = store || pad_we;
  assign ram_we    = cap_we || sw_win_we;
  assign ram_wdata = store ? trc_data : (pad_we ? '0 : bus_wdata);

  tcb_ptr #(.AW(AW)) u_wptr (
    .clk    (clk),
    .rst    (rst),
    .ld     (sw_ptr_ld),
    .ld_val (bus_wdata[AW-1:0]),
    .inc    (ram_we),
    .ptr    (wptr)
  );

  tcb_ptr #(.AW(AW)) u_rptr (
    .clk    (clk),
    .rst    (rst),
    .ld     (wr_rdptr),
    .ld_val (bus_wdata[AW-1:0]),
    .inc    (rd_win),
    .ptr    (rptr)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  full <= 1'b0;
    else if (sw_ptr_ld)                       full <= 1'b0;
    else if (cap_we && (wptr == {AW{1'b1}}))  full <= 1'b1;
  end

  logic [DATA_W-1:0] ram_q;
  tcb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (wptr),
    .wdata (ram_wdata),
    .re    (rd_win),
    .raddr (rptr),
    .rdata (ram_q)
  );

  // Two-stage read path
  logic              rd_q;
  logic [REG_AW-1:0] raddr_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      raddr_q <= '0;
    end else begin
      rd_q    <= bus_rd;
      if (bus_rd) raddr_q <= bus_addr;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (raddr_q)
      A_SIZE:   rd_mux = SIZE_WORD;
      A_STAT:   rd_mux = DATA_W'(full);
      A_RDWIN:  rd_mux = ram_q;
      A_RDPTR:  rd_mux = DATA_W'(rptr);
      A_WRPTR:  rd_mux = DATA_W'(wptr);
      A_TRGCNT: rd_mux = DATA_W'(trg_cnt);
      A_CTRL:   rd_mux = DATA_W'(cap_en);
      A_FSTAT:  rd_mux[B_STOPPED] = stopped;
      A_FCTRL: begin
        rd_mux[B_FMT_EN]   = fmt_en;
        rd_mux[B_FLUSH]    = flush_pend;
        rd_mux[B_STOP_FL]  = stop_fl;
        rd_mux[B_STOP_TRG] = stop_trg;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_q;
      if (rd_q) bus_rdata <= rd_mux;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> ##2 bus_rvalid); // R2
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (full && !sw_ptr_ld) |=> full); // R4
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stopped && !sw_ptr_ld && !sw_win_we) |=> $stable(wptr)); // R6
  AST_STOP_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (stopped && $past(st) == ST_PAD) |-> (wptr[1:0] == 2'b00)); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flush_req && flush_ack && !wr_fctrl) |=> !flush_req); // R10
endmodule

// File: tb/trace_capture_buffer_test.sv
`timescale 1ns/1ps
module trace_capture_buffer_test;
  localparam int DEPTH = 16;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic          trc_valid = 1'b0, trc_trig = 1'b0, flush_ack = 1'b0;
  logic [DW-1:0] trc_data = '0;
  logic          flush_req;

  always #10 clk = ~clk;

  trace_capture_buffer #(.DEPTH(DEPTH), .DATA_W(DW), .CNT_W(8)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trig(trc_trig),
    .flush_req(flush_req), .flush_ack(flush_ack)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic push(input logic [DW-1:0] d, input logic trig);
    trc_valid = 1'b1; trc_data = d; trc_trig = trig;
    @(negedge clk);
    trc_valid = 1'b0; trc_trig = 1'b0;
  endtask

  task automatic ack_pulse();
    flush_ack = 1'b1;
    @(negedge clk);
    flush_ack = 1'b0;
  endtask

  // op(3) addr(12) data(32) expect(32) tag(4)
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TR = 3'd2, OP_WT = 3'd3, OP_AK = 3'd4;
  localparam int NV = 83;
  localparam logic [82:0] VEC [NV] = '{
    {OP_RD, 12'h004, 32'h0,      32'd16,     4'd2},  // R2 size
    {OP_WR, 12'h304, 32'h1,      32'h0,      4'd7},
    {OP_WR, 12'h020, 32'h1,      32'h0,      4'd3},
    {OP_TR, 12'h000, 32'hA0,     32'h0,      4'd3},
    {OP_TR, 12'h000, 32'hA1,     32'h0,      4'd3},
    {OP_TR, 12'h000, 32'hA2,     32'h0,      4'd3},
    {OP_RD, 12'h300, 32'h0,      32'h0,      4'd3},  // R3 running
    {OP_RD, 12'h018, 32'h0,      32'd3,      4'd3},  // R3 wptr
    {OP_WR, 12'h024, 32'hDEAD,   32'h0,      4'd6},
    {OP_WR, 12'h018, 32'd9,      32'h0,      4'd6},
    {OP_RD, 12'h018, 32'h0,      32'd3,      4'd6},  // R6 ignored
    {OP_WR, 12'h020, 32'h0,      32'h0,      4'd7},
    {OP_WT, 12'h000, 32'd4,      32'h0,      4'd7},
    {OP_RD, 12'h300, 32'h0,      32'h2,      4'd7},  // R7 stopped
    {OP_RD, 12'h018, 32'h0,      32'd4,      4'd7},  // R7 padded
    {OP_WR, 12'h014, 32'h0,      32'h0,      4'd5},
    {OP_RD, 12'h010, 32'h0,      32'hA0,     4'd5},  // R5
    {OP_RD, 12'h010, 32'h0,      32'hA1,     4'd5},
    {OP_RD, 12'h010, 32'h0,      32'hA2,     4'd3},
    {OP_RD, 12'h010, 32'h0,      32'h0,      4'd7},  // R7 pad word
    {OP_RD, 12'h014, 32'h0,      32'd4,      4'd5},
    {OP_WR, 12'h018, 32'd14,     32'h0,      4'd6},
    {OP_WR, 12'h024, 32'h55,     32'h0,      4'd6},
    {OP_WR, 12'h024, 32'h66,     32'h0,      4'd6},
    {OP_RD, 12'h018, 32'h0,      32'd0,      4'd6},  // R6 window wrap
    {OP_RD, 12'h00C, 32'h0,      32'h0,      4'd4},  // R4 sw wrap no full
    {OP_WR, 12'h014, 32'd14,     32'h0,      4'd5},
    {OP_RD, 12'h010, 32'h0,      32'h55,     4'd6},
    {OP_RD, 12'h010, 32'h0,      32'h66,     4'd6},
    {OP_RD, 12'h014, 32'h0,      32'd0,      4'd5},  // R5 read wrap
    {OP_WR, 12'h304, 32'h0,      32'h0,      4'd7},
    {OP_WR, 12'h018, 32'h0,      32'h0,      4'd7},
    {OP_WR, 12'h020, 32'h1,      32'h0,      4'd7},
    {OP_TR, 12'h000, 32'hB0,     32'h0,      4'd7},
    {OP_TR, 12'h000, 32'hB1,     32'h0,      4'd7},
    {OP_WR, 12'h020, 32'h0,      32'h0,      4'd7},
    {OP_WT, 12'h000, 32'd2,      32'h0,      4'd7},
    {OP_RD, 12'h018, 32'h0,      32'd2,      4'd7},  // R7 no pad
    {OP_RD, 12'h300, 32'h0,      32'h2,      4'd7},
    {OP_WR, 12'h304, 32'h2001,   32'h0,      4'd8},
    {OP_WR, 12'h01C, 32'd3,      32'h0,      4'd8},
    {OP_WR, 12'h018, 32'd13,     32'h0,      4'd8},
    {OP_WR, 12'h020, 32'h1,      32'h0,      4'd8},
    {OP_TR, 12'h000, 32'hC0,     32'h0,      4'd8},
    {OP_TR, 12'h001, 32'hC1,     32'h0,      4'd8},  // trigger
    {OP_TR, 12'h000, 32'hC2,     32'h0,      4'd8},
    {OP_TR, 12'h000, 32'hC3,     32'h0,      4'd8},
    {OP_TR, 12'h000, 32'hC4,     32'h0,      4'd8},
    {OP_TR, 12'h000, 32'hC5,     32'h0,      4'd8},  // dropped
    {OP_WT, 12'h000, 32'd4,      32'h0,      4'd8},
    {OP_RD, 12'h01C, 32'h0,      32'd0,      4'd8},  // R8 count done
    {OP_RD, 12'h018, 32'h0,      32'd4,      4'd8},  // R8 stop + pad
    {OP_RD, 12'h00C, 32'h0,      32'h1,      4'd4},  // R4 full
    {OP_RD, 12'h300, 32'h0,      32'h2,      4'd8},
    {OP_WR, 12'h014, 32'd1,      32'h0,      4'd8},
    {OP_RD, 12'h010, 32'h0,      32'hC4,     4'd8},
    {OP_RD, 12'h010, 32'h0,      32'h0,      4'd8},
    {OP_RD, 12'h010, 32'h0,      32'h0,      4'd8},
    {OP_WR, 12'h014, 32'd15,     32'h0,      4'd4},
    {OP_RD, 12'h010, 32'h0,      32'hC2,     4'd4},
    {OP_WR, 12'h018, 32'h0,      32'h0,      4'd4},
    {OP_RD, 12'h00C, 32'h0,      32'h0,      4'd4},  // R4 cleared
    {OP_WR, 12'h304, 32'h1,      32'h0,      4'd9},
    {OP_WR, 12'h01C, 32'd1,      32'h0,      4'd9},
    {OP_WR, 12'h020, 32'h1,      32'h0,      4'd9},
    {OP_TR, 12'h001, 32'hD0,     32'h0,      4'd9},
    {OP_TR, 12'h000, 32'hD1,     32'h0,      4'd9},
    {OP_TR, 12'h000, 32'hD2,     32'h0,      4'd9},
    {OP_RD, 12'h300, 32'h0,      32'h0,      4'd9},  // R9 still running
    {OP_RD, 12'h018, 32'h0,      32'd3,      4'd9},
    {OP_RD, 12'h01C, 32'h0,      32'd1,      4'd9},
    {OP_WR, 12'h304, 32'h41,     32'h0,      4'd10},
    {OP_RD, 12'h304, 32'h0,      32'h41,     4'd10}, // R10 pending
    {OP_AK, 12'h000, 32'h0,      32'h0,      4'd10},
    {OP_RD, 12'h304, 32'h0,      32'h1,      4'd10}, // R10 cleared
    {OP_RD, 12'h300, 32'h0,      32'h0,      4'd11}, // R11 no stop
    {OP_WR, 12'h304, 32'h1041,   32'h0,      4'd11},
    {OP_TR, 12'h000, 32'hD3,     32'h0,      4'd11},
    {OP_AK, 12'h000, 32'h0,      32'h0,      4'd11},
    {OP_WT, 12'h000, 32'd4,      32'h0,      4'd11},
    {OP_RD, 12'h300, 32'h0,      32'h2,      4'd11}, // R11 stopped
    {OP_RD, 12'h018, 32'h0,      32'd4,      4'd11},
    {OP_RD, 12'h304, 32'h0,      32'h1001,   4'd11}
  };

  initial begin
    logic [DW-1:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 flush_req", DW'(flush_req), '0);
    check("R1 rvalid", DW'(bus_rvalid), '0);
    bus_read(12'h00C, got); check("R1 status", got, 32'h0);
    bus_read(12'h300, got); check("R1 fmt status", got, 32'h2);
    bus_read(12'h304, got); check("R1 fmt ctrl", got, 32'h0);
    bus_read(12'h014, got); check("R1 rptr", got, 32'h0);
    bus_read(12'h018, got); check("R1 wptr", got, 32'h0);
    bus_read(12'h01C, got); check("R1 trg cnt", got, 32'h0);
    bus_read(12'h020, got); check("R1 ctrl", got, 32'h0);

    // R2 read latency
    bus_rd = 1'b1; bus_addr = 12'h004;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R2 rvalid early", DW'(bus_rvalid), '0);
    @(negedge clk);
    check("R2 rvalid", DW'(bus_rvalid), 32'h1);
    check("R2 size", bus_rdata, 32'd16);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      automatic logic [82:0] v = VEC[i];
      automatic logic [2:0]  op = v[82:80];
      automatic logic [11:0] a  = v[79:68];
      automatic logic [31:0] d  = v[67:36];
      automatic logic [31:0] e  = v[35:4];
      automatic int          tg = int'(v[3:0]);
      case (op)
        OP_WR: bus_write(a, d);
        OP_RD: begin
          bus_read(a, got);
          check($sformatf("R%0d vec %0d addr %h", tg, i, a), got, e);
        end
        OP_TR: push(d, a[0]);
        OP_WT: repeat (int'(d)) @(negedge clk);
        default: ack_pulse();
      endcase
    end

    // R10 flush handshake seen at the ports while stopped
    bus_write(12'h304, 32'h40);
    check("R10 flush_req high", DW'(flush_req), 32'h1);
    ack_pulse();
    check("R10 flush_req low", DW'(flush_req), 32'h0);
    bus_read(12'h300, got); check("R11 idle flush keeps stopped", got, 32'h2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule